// File: doc/BRIEF.md
# Host Interrupt Request Control Unit

This block controls one output-buffer channel of a host-facing interface and turns it into level-type interrupt requests on two host interrupt lines. A slave-side processor writes a byte into an output data register, which raises a buffer-full flag. The host takes the byte with a read strobe, which drops the flag. A control register holds one enable bit per interrupt line. A separate mode bit decides how those enables act.

In flag-linked mode (mode bit 0), an enabled line requests an interrupt while the buffer-full flag is up. When the flag drops, both enables clear themselves, so software has to re-arm the lines for every byte. In direct mode (mode bit 1), an enable bit drives its request line on its own and the flag has no effect on it. An enable can be turned on only by a guarded sequence. Software must read the control register and see the bit at 0, and then write 1 to it in the very next access to that register. A write of 0 always clears the bit. A hardware reset or a synchronous software reset clears both enables and cancels any pending read-then-write sequence.

Top module: `hirq_ctrl`

## Requirements
- R1: After hardware reset, both request outputs and the buffer-full flag are 0, and reads of the control register (address 0) and the mode register (address 1) return 0.
- R2: A write of 1 to an enable bit (bit 7 for irq[1], bit 6 for irq[0] of the control register at address 0) sets it only when the most recent preceding access to address 0 was a read that returned that bit as 0. Otherwise the write of 1 leaves the bit unchanged.
- R3: Writing 0 to an enable bit clears it on the next clock edge.
- R4: A software reset pulse clears both enable bits and cancels pending read-then-write sequences, so a write of 1 after it has no effect unless a fresh read precedes it.
- R5: A slave write to address 2 sets the buffer-full flag and stores the byte. A host read strobe clears the flag. When both occur in the same cycle, the flag is set.
- R6: In mode 0, each request output, registered one cycle behind, equals its enable bit AND the buffer-full flag.
- R7: In mode 0, the clock edge at which the buffer-full flag drops also clears both enable bits.
- R8: In mode 1, each request output, one cycle behind, equals its enable bit whatever the flag, and a dropping flag leaves the enables unchanged.
- R9: Bits 5 to 0 of the control register and bits 7 to 1 of the mode register read as 0 and ignore writes.
- R10: The mode bit is bit 0 of address 1 and is read/write. Address 2 reads back the stored byte, which also appears on host_data. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset of the enable logic |
| sl_addr | input | 2 | Slave register address: 0 control, 1 mode, 2 output data |
| sl_rd | input | 1 | Slave read strobe |
| sl_wr | input | 1 | Slave write strobe |
| sl_wdata | input | 8 | Slave write data |
| sl_rdata | output | 8 | Slave read data (combinational) |
| host_rd | input | 1 | Host read strobe of the output data register |
| host_data | output | 8 | Stored output byte for the host |
| obf | output | 1 | Buffer-full flag |
| irq | output | 2 | Interrupt requests, irq[1] from bit 7, irq[0] from bit 6 |

## Verification
The assertions check on every cycle the rules that hold at any single edge. These are: the flag's set and clear with set winning, that an enable can only rise after an armed write of 1, the clearing done by a write of 0, by a software reset and by a dropping flag in mode 0, the quiet request lines when the flag is low in mode 0, and the zero low bits of the control register. Only the bench's scenarios show the longer sequences. These include the arm latch being consumed or re-targeted by an intervening read, enables surviving a dropping flag in mode 1, the one-cycle lag of the requests, and stale values after a software reset. A reference model follows these sequences across thousands of random accesses.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_MODE = 2'd1,
      RA_ODR  = 2'd2,
      RA_NONE = 2'd3
   } hirq_addr_e;
endpackage

// File: rtl/hirq_obf.sv
module hirq_obf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   input  logic              host_rd,
   output logic              full_o,
   output logic              fall_o,
   output logic [DATA_W-1:0] data_o
);
   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (load) begin
            full_q <= 1'b1;
            data_q <= wdata;
         end else if (host_rd) begin
            full_q <= 1'b0;
         end
      end
   end

   assign full_o = full_q;
   assign fall_o = full_q & host_rd & ~load;
   assign data_o = data_q;
endmodule

// File: rtl/hirq_en_bit.sv
module hirq_en_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wr_val,
   input  logic clr_evt,
   output logic en_o,
   output logic arm_o
);
   logic en_q;
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         arm_q <= 1'b0;
      end else if (sw_rst) begin
         en_q  <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (wr_hit) begin
            arm_q <= 1'b0;
            if (!wr_val)
               en_q <= 1'b0;
            else if (arm_q)
               en_q <= 1'b1;
         end else if (rd_hit) begin
            arm_q <= ~en_q;
         end
         if (clr_evt)
            en_q <= 1'b0;
      end
   end

   assign en_o  = en_q;
   assign arm_o = arm_q;
endmodule

// File: rtl/hirq_req.sv
module hirq_req #(
   parameter int N_LINES   = 2,
   parameter bit REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] req_d,
   output logic [N_LINES-1:0] req_o
);
   generate
      if (REGISTERED) begin : g_reg
         logic [N_LINES-1:0] req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               req_q <= '0;
            else
               req_q <= req_d;
         end
         assign req_o = req_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign req_o = req_d;
      end
   endgenerate
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl #(
   parameter int DATA_W      = 8,
   parameter int N_LINES     = 2,
   parameter bit REQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic [1:0]        sl_addr,
   input  logic              sl_rd,
   input  logic              sl_wr,
   input  logic [DATA_W-1:0] sl_wdata,
   output logic [DATA_W-1:0] sl_rdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_data,
   output logic              obf,
   output logic [N_LINES-1:0] irq
);
   import hirq_pkg::*;

   localparam int EN_LSB = DATA_W - N_LINES;

   generate
      if (N_LINES < 1 || N_LINES > DATA_W) begin : g_bad_lines
         $error("hirq_ctrl: N_LINES must be between 1 and DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("hirq_ctrl: DATA_W must be at least 2");
      end
   endgenerate

   logic ctrl_rd, ctrl_wr, mode_wr, odr_wr;
   logic flag_fall;
   logic mode_q;
   logic [N_LINES-1:0] en_vec;
   logic [N_LINES-1:0] arm_vec;
   logic [N_LINES-1:0] req_d;

   assign ctrl_wr = sl_wr & (sl_addr == RA_CTRL);
   assign ctrl_rd = sl_rd & ~sl_wr & (sl_addr == RA_CTRL);
   assign mode_wr = sl_wr & (sl_addr == RA_MODE);
   assign odr_wr  = sl_wr & (sl_addr == RA_ODR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= 1'b0;
      else if (mode_wr)
         mode_q <= sl_wdata[0];
   end

   hirq_obf #(.DATA_W(DATA_W)) obf_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (odr_wr),
      .wdata  (sl_wdata),
      .host_rd(host_rd),
      .full_o (obf),
      .fall_o (flag_fall),
      .data_o (host_data)
   );

   generate
      for (genvar k = 0; k < N_LINES; k++) begin : g_line
         hirq_en_bit en_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .rd_hit (ctrl_rd),
            .wr_hit (ctrl_wr),
            .wr_val (sl_wdata[EN_LSB+k]),
            .clr_evt(flag_fall & ~mode_q),
            .en_o   (en_vec[k]),
            .arm_o  (arm_vec[k])
         );
      end
   endgenerate

   assign req_d = mode_q ? en_vec : (en_vec & {N_LINES{obf}});

   hirq_req #(.N_LINES(N_LINES), .REGISTERED(REQ_REGISTERED)) req_i (
      .clk  (clk),
      .rst_n(rst_n),
      .req_d(req_d),
      .req_o(irq)
   );

   always_comb begin
      sl_rdata = '0;
      case (sl_addr)
         RA_CTRL: sl_rdata = DATA_W'(en_vec) << EN_LSB;
         RA_MODE: sl_rdata[0] = mode_q;
         RA_ODR:  sl_rdata = host_data;
         default: sl_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk #(
   parameter int DATA_W      = 8,
   parameter int N_LINES     = 2,
   parameter bit REQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_rst,
   input logic [1:0]        sl_addr,
   input logic              sl_rd,
   input logic              sl_wr,
   input logic [DATA_W-1:0] sl_wdata,
   input logic [DATA_W-1:0] sl_rdata,
   input logic              host_rd,
   input logic              obf,
   input logic [N_LINES-1:0] irq,
   input logic [N_LINES-1:0] en_vec,
   input logic [N_LINES-1:0] arm_vec,
   input logic              mode_q
);
   localparam int EN_LSB = DATA_W - N_LINES;

   logic c_ctrl_wr, c_odr_wr;
   assign c_ctrl_wr = sl_wr && (sl_addr == 2'd0);
   assign c_odr_wr  = sl_wr && (sl_addr == 2'd2);

   a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      c_odr_wr |=> obf);

   a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !c_odr_wr) |=> !obf);

   a_r4_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (en_vec == '0 && arm_vec == '0));

   a_r7_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && obf && host_rd && !c_odr_wr) |=> (en_vec == '0));

   a_r8_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && host_rd && !sw_rst && !c_ctrl_wr) |=> (en_vec == $past(en_vec)));

   generate
      if (EN_LSB > 0) begin : g_low
         a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (sl_addr == 2'd0) |-> (sl_rdata[EN_LSB-1:0] == '0));
      end
      if (REQ_REGISTERED) begin : g_reg
         a_r6_quiet_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_q && !obf) |=> (irq == '0));
      end
      for (genvar k = 0; k < N_LINES; k++) begin : g_bit
         a_r2_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[k] && !$past(en_vec[k])) |->
               $past(c_ctrl_wr && sl_wdata[EN_LSB+k] && arm_vec[k]));
         a_r3_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ctrl_wr && !sl_wdata[EN_LSB+k]) |=> !en_vec[k]);
      end
   endgenerate
endmodule

bind hirq_ctrl hirq_ctrl_chk #(
   .DATA_W(DATA_W), .N_LINES(N_LINES), .REQ_REGISTERED(REQ_REGISTERED)
) chk_i (
   .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .sl_addr(sl_addr),
   .sl_rd(sl_rd), .sl_wr(sl_wr), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata),
   .host_rd(host_rd), .obf(obf), .irq(irq), .en_vec(en_vec),
   .arm_vec(arm_vec), .mode_q(mode_q)
);

// File: tb/hirq_ctrl_tb_top.sv
module hirq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_rst = 1'b0;
   logic [1:0] sl_addr = '0;
   logic       sl_rd = 1'b0;
   logic       sl_wr = 1'b0;
   logic [7:0] sl_wdata = '0;
   logic [7:0] sl_rdata;
   logic       host_rd = 1'b0;
   logic [7:0] host_data;
   logic       obf;
   logic [1:0] irq;

   int n_tests = 0;
   int n_fail  = 0;

   // reference model state
   logic [1:0] m_en = '0, m_arm = '0, m_irq = '0;
   logic       m_mode = 1'b0, m_obf = 1'b0;
   logic [7:0] m_odr = '0;

   // values sampled at the start of the latest step
   logic [7:0] s_rdata;
   logic [1:0] s_irq;
   logic       s_obf;

   always #(CLK_PERIOD/2) clk = ~clk;

   hirq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .sl_addr(sl_addr),
      .sl_rd(sl_rd), .sl_wr(sl_wr), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata),
      .host_rd(host_rd), .host_data(host_data), .obf(obf), .irq(irq)
   );

   function automatic logic [7:0] exp_rdata(input logic [1:0] a);
      case (a)
         2'd0:    return {m_en[1], m_en[0], 6'b0};
         2'd1:    return {7'b0, m_mode};
         2'd2:    return m_odr;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                       input logic [7:0] d, input logic hr, input logic sr);
      logic [1:0] n_en, n_arm;
      logic       n_obf;
      @(negedge clk);
      sl_wr = wr; sl_rd = rd; sl_addr = a; sl_wdata = d; host_rd = hr; sw_rst = sr;
      #1;
      s_rdata = sl_rdata; s_irq = irq; s_obf = obf;
      chk(m_mode ? "R8 irq" : "R6 irq", {6'b0, irq}, {6'b0, m_irq});
      chk("R5 obf", {7'b0, obf}, {7'b0, m_obf});
      chk("R10 host_data", host_data, m_odr);
      if (rd) chk(a == 2'd0 ? "R2 ctrl read" : "R10 reg read", sl_rdata, exp_rdata(a));
      @(posedge clk);
      // model update from pre-edge state
      m_irq = m_mode ? m_en : (m_en & {2{m_obf}});
      n_obf = (wr && a == 2'd2) ? 1'b1 : (hr ? 1'b0 : m_obf);
      n_en = m_en; n_arm = m_arm;
      for (int k = 0; k < 2; k++) begin
         if (sr) begin
            n_en[k] = 1'b0; n_arm[k] = 1'b0;
         end else begin
            if (wr && a == 2'd0) begin
               n_arm[k] = 1'b0;
               if (!d[6+k]) n_en[k] = 1'b0;
               else if (m_arm[k]) n_en[k] = 1'b1;
            end else if (rd && a == 2'd0) begin
               n_arm[k] = ~m_en[k];
            end
            if (!m_mode && m_obf && !n_obf) n_en[k] = 1'b0;
         end
      end
      if (wr && a == 2'd1) m_mode = d[0];
      if (wr && a == 2'd2) m_odr = d;
      m_en = n_en; m_arm = n_arm; m_obf = n_obf;
   endtask

   task automatic idle();
      step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
   endtask
   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      step(1'b1, 1'b0, a, d, 1'b0, 1'b0);
   endtask
   task automatic rreg(input logic [1:0] a);
      step(1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      idle();
      chk("R1 irq", {6'b0, s_irq}, 8'h00);
      chk("R1 obf", {7'b0, s_obf}, 8'h00);
      rreg(2'd1);
      chk("R1 mode", s_rdata, 8'h00);
      // R2 write 1 without a preceding read
      wreg(2'd0, 8'hC0);
      rreg(2'd0);
      chk("R2 unarmed write", s_rdata, 8'h00);
      wreg(2'd0, 8'h80);
      rreg(2'd0);
      chk("R2 armed write", s_rdata, 8'h80);
      wreg(2'd0, 8'hC0);
      rreg(2'd0);
      chk("R2 second bit", s_rdata, 8'hC0);
      // R3 write 0 clears
      wreg(2'd0, 8'h40);
      rreg(2'd0);
      chk("R3 clear bit7", s_rdata, 8'h40);
      // R6 flag-linked request
      idle();
      chk("R6 no flag", {6'b0, s_irq}, 8'h00);
      wreg(2'd2, 8'h5A);
      idle();
      chk("R5 set", {7'b0, s_obf}, 8'h01);
      idle();
      chk("R6 request", {6'b0, s_irq}, 8'h01);
      chk("R10 host data", host_data, 8'h5A);
      // R7 host read drops flag and enables
      step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
      rreg(2'd0);
      chk("R5 clear", {7'b0, s_obf}, 8'h00);
      chk("R7 enables cleared", s_rdata, 8'h00);
      idle();
      chk("R6 request drops", {6'b0, s_irq}, 8'h00);
      // R5 set wins over clear
      step(1'b1, 1'b0, 2'd2, 8'h33, 1'b1, 1'b0);
      idle();
      chk("R5 set wins", {7'b0, s_obf}, 8'h01);
      step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
      // R8 direct mode
      wreg(2'd1, 8'h01);
      rreg(2'd1);
      chk("R10 mode bit", s_rdata, 8'h01);
      rreg(2'd0);
      wreg(2'd0, 8'hC0);
      idle();
      idle();
      chk("R8 direct request", {6'b0, s_irq}, 8'h03);
      wreg(2'd2, 8'hA5);
      step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
      rreg(2'd0);
      chk("R8 enables kept", s_rdata, 8'hC0);
      rreg(2'd2);
      chk("R10 odr readback", s_rdata, 8'hA5);
      // R4 software reset
      step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
      rreg(2'd0);
      chk("R4 enables cleared", s_rdata, 8'h00);
      step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
      wreg(2'd0, 8'hC0);
      rreg(2'd0);
      chk("R4 arm cancelled", s_rdata, 8'h00);
      // R9 unused bits
      wreg(2'd0, 8'hFF);
      rreg(2'd0);
      chk("R9 ctrl low bits", s_rdata, 8'hC0);
      wreg(2'd1, 8'hFE);
      rreg(2'd1);
      chk("R9 mode high bits", s_rdata, 8'h00);
      rreg(2'd3);
      chk("R10 unused address", s_rdata, 8'h00);

      // constrained random phase against the model
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4000; i++) begin
         int unsigned op;
         logic wr, rd;
         op = $urandom_range(0, 9);
         wr = (op < 4);
         rd = (op >= 4 && op < 8);
         step(wr, rd, 2'($urandom_range(0, 3)), 8'($urandom()),
              ($urandom_range(0, 4) == 0), ($urandom_range(0, 40) == 0));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule